// File: doc/BRIEF.md
# Character pixel colour, blink and pin output stage

This block sits at the end of an on-screen character display pipeline. In each pixel cycle it receives three inputs: the 16-bit display memory word of the character cell being scanned, the glyph dot bit for the current pixel, and a flag that says whether the pixel lies inside a character cell. From these it decides the pixel colour. A glyph dot takes the character's foreground colour. A non-dot position inside the cell takes the background colour. Positions outside any cell are black and not blanked. A per-character blink flag lets a character's glyph disappear periodically while its background stays visible.

Blink timing comes from a small two-state machine. It counts vertical sync pulses over a period of 32 or 64 frames, and a selectable share of that period is the visible part. Period and duty settings are latched only when a period ends, so a change never produces a truncated or stretched blink.

The eight output pins are registered. Four of them (pins 0, 1, 3 and 5) are shared: each one either drives a static level or carries a video signal (blanking, red, green or blue). The same data bit sets the static level in the first case and the polarity in the second. Pins 2, 4, 6 and 7 are always static ports.

Top module: `chr_pixel_out`

## Requirements
- R1: While `rst_n` is low, `pins` is 0. The blink counter is cleared, the machine is in SHOW, and the latched blink configuration is period 32 with duty code 00.
- R2: Memory word fields: bits 7:0 hold the character code (not used for colour), bits 10:8 the foreground R,G,B, bit 11 the blink flag, bits 14:12 the background R,G,B, and bit 15 is reserved. R is the lowest bit of each triple.
- R3: When `in_cell` is 1, the pixel colour is the foreground if `dot` is 1 and the glyph is not suppressed, and the background otherwise. When `in_cell` is 0, the colour is 000.
- R4: The blanking signal is 1 exactly when `in_cell` is 1 and the chosen colour is not 000.
- R5: A shared pin whose `port_mode` bit is 0 outputs its `pin_data` bit. `port_mode` bit 0 controls pin 0, bit 1 controls pin 1, bit 2 controls pin 3 and bit 3 controls pin 5.
- R6: A shared pin whose `port_mode` bit is 1 outputs its video signal: pin 0 carries blanking, pin 1 R, pin 3 G and pin 5 B. The signal is passed unchanged when the pin's `pin_data` bit is 1 and inverted when it is 0.
- R7: Pins 2, 4, 6 and 7 always output their `pin_data` bits.
- R8: The blink period is 32 `vsync` pulses when the latched `blink_long` is 0 and 64 when it is 1. Duty code 01, 10 or 11 keeps the glyph visible for the first 1/4, 1/2 or 3/4 of the period. Code 00 disables blinking.
- R9: During the hidden phase, a character with its blink flag set shows its background on dot positions. Characters without the flag are not affected.
- R10: `blink_long` and `blink_duty` are sampled only at the `vsync` that ends a period. Changes made at any other time have no effect until then.
- R11: `pins` reflects the inputs of the previous clock edge. A `vsync` on that same edge moves the blink phase only for later pixels.

The blink machine has two states. SHOW goes to HIDE on the `vsync` that brings the count to the visible length. SHOW stays in SHOW, with the counter wrapping and the configuration reloading, on the `vsync` that ends the period while blinking is disabled. HIDE returns to SHOW, with the same wrap and reload, on the `vsync` that ends the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | One-cycle pulse per frame |
| blink_long | input | 1 | Period select: 0 = 32 frames, 1 = 64 frames |
| blink_duty | input | 2 | Visible share: 00 off, 01 1/4, 10 1/2, 11 3/4 |
| cell_word | input | 16 | Display memory word of the current character |
| dot | input | 1 | Glyph dot bit of the current pixel |
| in_cell | input | 1 | Pixel lies inside a character cell |
| port_mode | input | 4 | Video select for pins 0, 1, 3, 5 |
| pin_data | input | 8 | Port level or polarity per pin |
| pins | output | 8 | Registered pin levels |

## Verification
The case that matters is a `vsync` that switches the blink phase arriving in the same cycle as a blinking glyph dot. The bench places a pixel of a blinking character on every `vsync` and varies the dot bit, the blink flag and the polarity. Its reference model computes the expected pin levels from the phase as it stood before the pulse and only afterwards advances its own frame count. A design that applies the new phase to the coincident pixel therefore miscompares exactly at the visible/hidden boundaries. The same stream also moves the period and duty inputs in the middle of a period, which tests that the new settings are only picked up at the period end.

// File: rtl/chr_pix_pkg.sv
package chr_pix_pkg;

    typedef enum logic {
        PH_SHOW = 1'b0,
        PH_HIDE = 1'b1
    } blink_ph_t;

    typedef struct packed {
        logic       rsvd;
        logic [2:0] bg;
        logic       blink;
        logic [2:0] fg;
        logic [7:0] code;
    } cell_word_t;

    localparam int NUM_PINS   = 8;
    localparam int NUM_SHARED = 4;

endpackage

// File: rtl/chr_blink_fsm.sv
module chr_blink_fsm
    import chr_pix_pkg::*;
#(
    parameter int BASE_DIV = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsync,
    input  logic       blink_long,
    input  logic [1:0] blink_duty,
    output logic       hide
);

    localparam int CW    = $clog2(2 * BASE_DIV);
    localparam int QUART = BASE_DIV / 4;
    localparam logic [CW-1:0] LAST_S = CW'(BASE_DIV - 1);
    localparam logic [CW-1:0] LAST_L = CW'(2 * BASE_DIV - 1);
    localparam logic [CW:0]   Q_S    = (CW+1)'(QUART);
    localparam logic [CW:0]   Q_L    = (CW+1)'(2 * QUART);

    blink_ph_t       state, nxt_state;
    logic [CW-1:0]   cnt;
    logic            lat_long;
    logic [1:0]      lat_duty;
    logic [CW-1:0]   last;
    logic [CW:0]     quart, on_len, cnt_inc;
    logic            wrap, reach;

    always_comb begin
        last    = lat_long ? LAST_L : LAST_S;
        quart   = lat_long ? Q_L : Q_S;
        unique case (lat_duty)
            2'b01:   on_len = quart;
            2'b10:   on_len = quart << 1;
            2'b11:   on_len = quart + (quart << 1);
            default: on_len = '0;
        endcase
        cnt_inc = {1'b0, cnt} + 1'b1;
        wrap    = vsync && (cnt == last);
        reach   = vsync && !wrap && (lat_duty != 2'b00) && (cnt_inc == on_len);
    end

    // next-state decision
    always_comb begin
        nxt_state = state;
        unique case (state)
            PH_SHOW: begin
                if (wrap)       nxt_state = PH_SHOW;
                else if (reach) nxt_state = PH_HIDE;
            end
            PH_HIDE: begin
                if (wrap)       nxt_state = PH_SHOW;
            end
            default: nxt_state = PH_SHOW;
        endcase
    end

    // state register, frame counter and configuration latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= PH_SHOW;
            cnt      <= '0;
            lat_long <= 1'b0;
            lat_duty <= 2'b00;
        end else begin
            state <= nxt_state;
            if (wrap) begin
                cnt      <= '0;
                lat_long <= blink_long;
                lat_duty <= blink_duty;
            end else if (vsync) begin
                cnt <= cnt_inc[CW-1:0];
            end
        end
    end

    // outputs per state
    always_comb begin
        unique case (state)
            PH_HIDE: hide = 1'b1;
            default: hide = 1'b0;
        endcase
    end

endmodule

// File: rtl/chr_color_sel.sv
module chr_color_sel
    import chr_pix_pkg::*;
(
    input  logic [15:0] cell_word,
    input  logic        dot,
    input  logic        in_cell,
    input  logic        hide,
    output logic [2:0]  rgb,
    output logic        blank
);

    cell_word_t w;
    logic       show_fg;

    always_comb begin
        w       = cell_word_t'(cell_word);
        show_fg = dot && !(w.blink && hide);
        if (!in_cell)     rgb = 3'b000;
        else if (show_fg) rgb = w.fg;
        else              rgb = w.bg;
        blank = in_cell && (rgb != 3'b000);
    end

endmodule

// File: rtl/chr_pin_mux.sv
module chr_pin_mux
    import chr_pix_pkg::*;
#(
    parameter int NPIN = NUM_PINS
) (
    input  logic [2:0]      rgb,
    input  logic            blank,
    input  logic [3:0]      port_mode,
    input  logic [NPIN-1:0] pin_data,
    output logic [NPIN-1:0] lvl
);

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        if (i == 0 || i == 1 || i == 3 || i == 5) begin : g_shared
            localparam int K = (i == 0) ? 0 : (i == 1) ? 1 : (i == 3) ? 2 : 3;
            logic vid;
            assign vid    = (K == 0) ? blank : rgb[K-1];
            assign lvl[i] = port_mode[K] ? (vid ^ ~pin_data[i]) : pin_data[i];
        end else begin : g_fixed
            assign lvl[i] = pin_data[i];
        end
    end

endmodule

// File: rtl/chr_pixel_out.sv
module chr_pixel_out
    import chr_pix_pkg::*;
#(
    parameter int BASE_DIV = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vsync,
    input  logic        blink_long,
    input  logic [1:0]  blink_duty,
    input  logic [15:0] cell_word,
    input  logic        dot,
    input  logic        in_cell,
    input  logic [3:0]  port_mode,
    input  logic [7:0]  pin_data,
    output logic [7:0]  pins
);

    logic       blink_hide;
    logic [2:0] pix_rgb;
    logic       pix_blank;
    logic [7:0] pin_lvl;

    chr_blink_fsm #(.BASE_DIV(BASE_DIV)) blink_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .vsync      (vsync),
        .blink_long (blink_long),
        .blink_duty (blink_duty),
        .hide       (blink_hide)
    );

    chr_color_sel color_i (
        .cell_word (cell_word),
        .dot       (dot),
        .in_cell   (in_cell),
        .hide      (blink_hide),
        .rgb       (pix_rgb),
        .blank     (pix_blank)
    );

    chr_pin_mux #(.NPIN(8)) mux_i (
        .rgb       (pix_rgb),
        .blank     (pix_blank),
        .port_mode (port_mode),
        .pin_data  (pin_data),
        .lvl       (pin_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins <= '0;
        else        pins <= pin_lvl;
    end

endmodule

// File: rtl/chr_pixel_out_chk.sv
module chr_pixel_out_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vsync,
    input logic       in_cell,
    input logic [3:0] port_mode,
    input logic [7:0] pin_data,
    input logic [7:0] pins,
    input logic       hide
);

    // R7
    fixed_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pins[2] == $past(pin_data[2])) && (pins[4] == $past(pin_data[4]))
              && (pins[6] == $past(pin_data[6])) && (pins[7] == $past(pin_data[7])));

    // R5
    port_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_mode[1] == 1'b0) |=> (pins[1] == $past(pin_data[1])));

    // R3
    outside_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_cell && port_mode == 4'hF && pin_data[0] && pin_data[1] && pin_data[3] && pin_data[5])
        |=> (pins[0] == 1'b0) && (pins[1] == 1'b0) && (pins[3] == 1'b0) && (pins[5] == 1'b0));

    // R8
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable(hide));

endmodule

bind chr_pixel_out chr_pixel_out_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .vsync     (vsync),
    .in_cell   (in_cell),
    .port_mode (port_mode),
    .pin_data  (pin_data),
    .pins      (pins),
    .hide      (blink_hide)
);

// File: tb/chr_pixel_out_tb_top.sv
module chr_pixel_out_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vsync = 1'b0;
    logic        blink_long = 1'b0;
    logic [1:0]  blink_duty = 2'b00;
    logic [15:0] cell_word = '0;
    logic        dot = 1'b0;
    logic        in_cell = 1'b0;
    logic [3:0]  port_mode = '0;
    logic [7:0]  pin_data = '0;
    logic [7:0]  pins;

    logic        vec_valid = 1'b0;
    int          n_vec = 0;
    int          n_bad = 0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];

    // reference blink model
    int          m_cnt = 0;
    logic        m_hide = 1'b0;
    logic        m_long = 1'b0;
    logic [1:0]  m_duty = 2'b00;

    always #5 clk = ~clk;

    chr_pixel_out dut_i (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .blink_long(blink_long),
        .blink_duty(blink_duty), .cell_word(cell_word), .dot(dot),
        .in_cell(in_cell), .port_mode(port_mode), .pin_data(pin_data), .pins(pins)
    );

    function automatic logic [15:0] mkword(logic [2:0] bg, logic bl, logic [2:0] fg, logic [7:0] code);
        return {1'b0, bg, bl, fg, code};
    endfunction

    function automatic logic [7:0] exp_pins(logic [15:0] w, logic d, logic inc,
                                            logic [3:0] md, logic [7:0] dat, logic hd);
        logic [2:0] c;
        logic       bk;
        logic [7:0] p;
        if (!inc)                   c = 3'b000;
        else if (d && !(w[11] && hd)) c = w[10:8];
        else                        c = w[14:12];
        bk = inc && (c != 3'b000);
        p = dat;
        if (md[0]) p[0] = dat[0] ? bk   : ~bk;
        if (md[1]) p[1] = dat[1] ? c[0] : ~c[0];
        if (md[2]) p[3] = dat[3] ? c[1] : ~c[1];
        if (md[3]) p[5] = dat[5] ? c[2] : ~c[2];
        return p;
    endfunction

    task automatic model_vsync();
        int len, on_len;
        len = m_long ? 64 : 32;
        if (m_cnt == len - 1) begin
            m_cnt  = 0;
            m_hide = 1'b0;
            m_long = blink_long;
            m_duty = blink_duty;
        end else begin
            m_cnt = m_cnt + 1;
            on_len = (len / 4) * int'(m_duty);
            if (m_duty != 2'b00 && m_cnt == on_len) m_hide = 1'b1;
        end
    endtask

    task automatic apply(logic [15:0] w, logic d, logic inc, logic vs,
                         logic [3:0] md, logic [7:0] dat, string tag);
        @(negedge clk);
        cell_word = w; dot = d; in_cell = inc; vsync = vs;
        port_mode = md; pin_data = dat; vec_valid = 1'b1;
        exp_q.push_back(exp_pins(w, d, inc, md, dat, m_hide));
        tag_q.push_back(tag);
        if (vs) model_vsync();
    endtask

    task automatic idle();
        @(negedge clk);
        vec_valid = 1'b0; vsync = 1'b0;
    endtask

    // monitor: compares two time units after the edge that registered the vector
    always @(posedge clk) begin
        if (vec_valid && rst_n) begin
            logic [7:0] e;
            string      t;
            #2;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (pins !== e) begin
                n_bad++;
                $display("FAIL %s: pins=%b expected=%b", t, pins, e);
            end
        end
    end

    initial begin : watchdog
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        logic [15:0] wb, wn;
        repeat (3) @(negedge clk);
        // R1: reset state observed at the pins
        n_vec++;
        if (pins !== 8'h00) begin
            n_bad++;
            $display("FAIL R1: pins=%b expected=%b", pins, 8'h00);
        end
        rst_n = 1'b1;
        // R5 R7: static port levels
        apply('0, 1'b0, 1'b0, 1'b0, 4'h0, 8'hA5, "R5 R7 port levels");
        apply('0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h5A, "R5 R7 port levels");
        // R2 R3 R4 R6: foreground dot, positive polarity
        apply(mkword(3'b010, 1'b0, 3'b101, 8'h41), 1'b1, 1'b1, 1'b0, 4'hF, 8'hFF, "R2 R3 R6 fg dot");
        // R3: background on non-dot
        apply(mkword(3'b010, 1'b0, 3'b101, 8'h41), 1'b0, 1'b1, 1'b0, 4'hF, 8'hFF, "R3 bg");
        // R4: black background gives no blanking
        apply(mkword(3'b000, 1'b0, 3'b101, 8'h41), 1'b0, 1'b1, 1'b0, 4'hF, 8'hFF, "R4 black bg");
        // R3: outside cell
        apply(mkword(3'b111, 1'b0, 3'b111, 8'h20), 1'b1, 1'b0, 1'b0, 4'hF, 8'hFF, "R3 outside cell");
        // R6: negative polarity
        apply(mkword(3'b001, 1'b0, 3'b110, 8'h20), 1'b1, 1'b1, 1'b0, 4'hF, 8'h00, "R6 negative polarity");
        // R5 R6: mixed modes
        apply(mkword(3'b001, 1'b0, 3'b110, 8'h20), 1'b1, 1'b1, 1'b0, 4'b0101, 8'b1101_0110, "R5 R6 mixed");
        // R9: blink flag set, phase shown after reset
        apply(mkword(3'b100, 1'b1, 3'b011, 8'h7F), 1'b1, 1'b1, 1'b0, 4'hF, 8'hFF, "R9 shown after reset");
        idle();

        // R8 R9 R10 R11: vsync stream with blinking pixels on every pulse
        wb = mkword(3'b010, 1'b1, 3'b111, 8'h30);
        wn = mkword(3'b100, 1'b0, 3'b001, 8'h31);
        blink_duty = 2'b01;
        for (int i = 0; i < 260; i++) begin
            logic [15:0] w;
            logic [7:0]  dat;
            if (i == 52)  begin blink_long = 1'b1; blink_duty = 2'b11; end
            if (i == 140) begin blink_long = 1'b0; blink_duty = 2'b10; end
            if (i == 230) begin blink_duty = 2'b00; end
            w   = (i % 3 == 0) ? wn : wb;
            dat = (i % 5 == 0) ? 8'h00 : 8'hFF;
            apply(w, (i % 4 != 1), 1'b1, 1'b1, 4'hF, dat, "R8 R9 R10 R11 blink");
            apply(wb, 1'b1, 1'b1, 1'b0, 4'hF, 8'hFF, "R9 blink between pulses");
        end
        idle();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule